// File: doc/BRIEF.md
# Banked Stack Pointer Register File

This block holds the sixteen architectural registers of a small 32-bit processor core. Indices 0 to 12 are general-purpose data registers, index 14 holds subroutine return addresses, index 15 is the program counter and index 13 is a stack pointer. The stack pointer exists in two copies, one for kernel and handler code and one for thread code. A mode bit picks which copy index 13 reaches. The hidden copy stays reachable through a separate pair of special-access ports.

Two combinational read ports and one write port serve the datapath. A push or pop command moves the active stack pointer by one word and returns the memory address for that transfer in the same cycle. The program counter reads one word ahead of the executing instruction and advances by two or four bytes on request. A write to index 15 acts as a branch. A branch target with bit 0 clear is refused and reported on a fault output.

Top module: `banked_regfile`

## Requirements
- R1: Indices 0 to 12 and 14 hold the last value written through the write port and show it on both read ports. They read as zero after reset.
- R2: The stack select bit `psp_active` is 0 (main copy) after reset and takes `ctl_psp_sel` one edge after `ctl_wr_en`. Index 13 reads and writes only the copy that this bit selects. The other copy is unchanged by such a write.
- R3: Bits 1:0 of both stack pointer copies always read as zero, whatever value was written. Writing 0xFFFFFFFF reads back as 0xFFFFFFFC.
- R4: The special ports read (`spec_rd_sel`, 0 = main, 1 = process) and write (`spec_wr_sel`) either copy, whichever copy is selected. In one cycle, a write-port write to index 13 takes precedence over a special write to the same copy.
- R5: During `stk_push`, `stk_addr` equals the active stack pointer minus 4 in that cycle. After the edge, the active copy holds that value.
- R6: During `stk_pop` alone, `stk_addr` equals the active stack pointer. After the edge, the active copy is 4 higher.
- R7: A push and a pop in the same cycle act as a push only. A push or pop takes precedence over any write to the active copy in that cycle.
- R8: Bit 0 of index 14 is stored and read back like every other bit.
- R9: Reading index 15 returns the current instruction address plus 4, with bit 0 reading as 0. Each edge with `pc_adv` set advances the address by 4 when `pc_adv_wide` is 1, and by 2 otherwise.
- R10: A write to index 15 with bit 0 set loads the written value with bit 0 cleared into the program counter. It does not change index 14 and does not raise `branch_fault`.
- R11: A write to index 15 with bit 0 clear leaves the program counter unchanged, even when an advance is requested. It sets `branch_fault` for exactly the one cycle after the edge.
- R12: A read of a register that is written in the same cycle returns the value held before that write.
- R13: After reset the program counter equals the `RESET_PC` parameter (0 by default), so index 15 reads `RESET_PC + 4`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctl_wr_en | input | 1 | Load the stack select bit |
| ctl_psp_sel | input | 1 | New stack select value (1 = process copy) |
| psp_active | output | 1 | Current stack select bit |
| rd_a_idx | input | 4 | Read port A index |
| rd_a_data | output | 32 | Read port A data |
| rd_b_idx | input | 4 | Read port B index |
| rd_b_data | output | 32 | Read port B data |
| wr_en | input | 1 | Write port enable |
| wr_idx | input | 4 | Write port index |
| wr_data | input | 32 | Write port data |
| spec_rd_sel | input | 1 | Special read copy select (0 main, 1 process) |
| spec_rd_data | output | 32 | Special read data |
| spec_wr_en | input | 1 | Special write enable |
| spec_wr_sel | input | 1 | Special write copy select (0 main, 1 process) |
| spec_wr_data | input | 32 | Special write data |
| stk_push | input | 1 | Push command |
| stk_pop | input | 1 | Pop command |
| stk_addr | output | 32 | Memory address for the current push or pop |
| pc_adv | input | 1 | Advance the program counter |
| pc_adv_wide | input | 1 | Advance by 4 instead of 2 |
| pc_addr | output | 32 | Address of the executing instruction |
| branch_fault | output | 1 | Illegal branch target seen on the previous edge |

## Verification
Read data and `stk_addr` are combinational, so each is due in the same cycle its index or command is applied. Stack pointer, program counter and register updates are due one edge later. `branch_fault` rises one edge after an illegal branch write and drops on the next edge. The bench drives inputs one time unit after a rising edge. It samples combinational results one unit after that, and samples registered results only after the following edge. This also lets it check that a same-cycle read still shows the old value.

// File: rtl/brf_pkg.sv
package brf_pkg;

   localparam int unsigned NUM_REGS  = 16;
   localparam int unsigned IDX_W     = 4;
   localparam int unsigned NUM_BANKS = 2;
   localparam int unsigned NUM_RD    = 2;

   localparam logic [IDX_W-1:0] SP_IDX = 4'd13;
   localparam logic [IDX_W-1:0] LR_IDX = 4'd14;
   localparam logic [IDX_W-1:0] PC_IDX = 4'd15;

   typedef enum logic {
      BANK_MAIN = 1'b0,
      BANK_PROC = 1'b1
   } sp_bank_e;

endpackage

// File: rtl/brf_gpr_bank.sv
module brf_gpr_bank
   import brf_pkg::*;
#(
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] gpr_q [NUM_REGS]
);

   // Plain storage for every index except the banked stack slot and the
   // program counter; those two slots read as zero here and are muxed
   // from their own units at the read ports.
   for (genvar i = 0; i < NUM_REGS; i++) begin : g_ent
      if (IDX_W'(i) == SP_IDX || IDX_W'(i) == PC_IDX) begin : g_hole
         assign gpr_q[i] = '0;
      end else begin : g_reg
         logic [DATA_W-1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               q <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(i))) begin
               q <= wr_data;
            end
         end
         assign gpr_q[i] = q;
      end
   end

   // R1 / R8: a plain write lands with every bit intact on the next edge
   a_r1_write_lands : assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_idx != SP_IDX && wr_idx != PC_IDX)
      |=> gpr_q[$past(wr_idx)] == $past(wr_data));

endmodule

// File: rtl/brf_sp_bank.sv
module brf_sp_bank
   import brf_pkg::*;
#(
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned ALIGN_BITS = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctl_wr_en,
   input  logic              ctl_psp_sel,
   input  logic              gen_wr_en,
   input  logic [DATA_W-1:0] gen_wr_data,
   input  logic              spec_wr_en,
   input  logic              spec_wr_sel,
   input  logic [DATA_W-1:0] spec_wr_data,
   input  logic              spec_rd_sel,
   input  logic              push,
   input  logic              pop,
   output logic              psp_active,
   output logic [DATA_W-1:0] active_sp,
   output logic [DATA_W-1:0] spec_rd_data,
   output logic [DATA_W-1:0] stk_addr
);

   localparam logic [DATA_W-1:0] STEP      = DATA_W'(1) << ALIGN_BITS;
   localparam logic [DATA_W-1:0] KEEP_MASK = ~(STEP - DATA_W'(1));

   if (ALIGN_BITS < 1 || ALIGN_BITS >= DATA_W) begin : g_bad_align
      $error("brf_sp_bank: ALIGN_BITS must lie in 1..DATA_W-1");
   end

   logic [DATA_W-1:0] sp_q [NUM_BANKS];
   logic [DATA_W-1:0] sp_dec;
   logic [DATA_W-1:0] sp_inc;

   // Stack select bit; the main copy is active out of reset
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         psp_active <= BANK_MAIN;
      end else if (ctl_wr_en) begin
         psp_active <= ctl_psp_sel;
      end
   end

   assign active_sp    = sp_q[psp_active];
   assign sp_dec       = active_sp - STEP;
   assign sp_inc       = active_sp + STEP;
   assign stk_addr     = push ? sp_dec : active_sp;
   assign spec_rd_data = sp_q[spec_rd_sel];

   // One copy per bank; priority: push, pop, write port, special port
   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      logic              is_act;
      logic              is_spec;
      logic [DATA_W-1:0] q;

      assign is_act  = (psp_active == 1'(b));
      assign is_spec = spec_wr_en && (spec_wr_sel == 1'(b));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            q <= '0;
         end else if (is_act && push) begin
            q <= sp_dec;
         end else if (is_act && pop) begin
            q <= sp_inc;
         end else if (is_act && gen_wr_en) begin
            q <= gen_wr_data & KEEP_MASK;
         end else if (is_spec) begin
            q <= spec_wr_data & KEEP_MASK;
         end
      end

      assign sp_q[b] = q;
   end

   // R2: select comes out of reset on the main copy
   a_r2_reset_main : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (psp_active == BANK_MAIN));

   // R2: select follows a control write on the next edge
   a_r2_select_load : assert property (@(posedge clk) disable iff (!rst_n)
      ctl_wr_en |=> (psp_active == $past(ctl_psp_sel)));

   // R3: alignment bits of both copies stay clear
   a_r3_low_bits_zero : assert property (@(posedge clk) disable iff (!rst_n)
      (active_sp[ALIGN_BITS-1:0] == '0) && (spec_rd_data[ALIGN_BITS-1:0] == '0));

   // R5: push lowers the copy that was active by one word
   a_r5_push_lowers : assert property (@(posedge clk) disable iff (!rst_n)
      push |=> (sp_q[$past(psp_active)] == $past(active_sp) - STEP));

   // R6: lone pop raises the copy that was active by one word
   a_r6_pop_raises : assert property (@(posedge clk) disable iff (!rst_n)
      (pop && !push) |=> (sp_q[$past(psp_active)] == $past(active_sp) + STEP));

   // R5 / R6: the address handed out always stays word aligned
   a_r5_addr_aligned : assert property (@(posedge clk) disable iff (!rst_n)
      (push || pop) |-> (stk_addr[ALIGN_BITS-1:0] == '0));

endmodule

// File: rtl/brf_pc_unit.sv
module brf_pc_unit
   import brf_pkg::*;
#(
   parameter int unsigned       DATA_W   = 32,
   parameter logic [DATA_W-1:0] RESET_PC = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              adv,
   input  logic              adv_wide,
   output logic [DATA_W-1:0] pc_q,
   output logic [DATA_W-1:0] pc_rd,
   output logic              fault
);

   localparam logic [DATA_W-1:0] STEP_WIDE   = DATA_W'(4);
   localparam logic [DATA_W-1:0] STEP_NARROW = DATA_W'(2);
   localparam logic [DATA_W-1:0] READ_AHEAD  = DATA_W'(4);

   if (RESET_PC[0] != 1'b0) begin : g_bad_reset_pc
      $error("brf_pc_unit: RESET_PC must be halfword aligned");
   end

   logic              pc_wr;
   logic              br_legal;
   logic              br_illegal;
   logic [DATA_W-1:0] pc_step;
   logic [DATA_W-1:0] ahead;

   assign pc_wr      = wr_en && (wr_idx == PC_IDX);
   assign br_legal   = pc_wr && wr_data[0];
   assign br_illegal = pc_wr && !wr_data[0];
   assign pc_step    = adv_wide ? STEP_WIDE : STEP_NARROW;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_q  <= RESET_PC;
         fault <= 1'b0;
      end else begin
         fault <= br_illegal;
         if (br_legal) begin
            pc_q <= {wr_data[DATA_W-1:1], 1'b0};
         end else if (!pc_wr && adv) begin
            pc_q <= pc_q + pc_step;
         end
      end
   end

   assign ahead = pc_q + READ_AHEAD;
   assign pc_rd = {ahead[DATA_W-1:1], 1'b0};

   // R10: legal branch loads the target with bit 0 dropped, no fault
   a_r10_branch_target : assert property (@(posedge clk) disable iff (!rst_n)
      br_legal |=> (pc_q == {$past(wr_data[DATA_W-1:1]), 1'b0}) && !fault);

   // R11: illegal target faults and leaves the counter where it was
   a_r11_fault_holds_pc : assert property (@(posedge clk) disable iff (!rst_n)
      br_illegal |=> fault && (pc_q == $past(pc_q)));

   // R11: fault lasts one cycle only
   a_r11_fault_pulse : assert property (@(posedge clk) disable iff (!rst_n)
      !br_illegal |=> !fault);

   // R9: advance by two or four bytes
   a_r9_advance_step : assert property (@(posedge clk) disable iff (!rst_n)
      (adv && !pc_wr) |=> (pc_q == $past(pc_q) + ($past(adv_wide) ? STEP_WIDE : STEP_NARROW)));

endmodule

// File: rtl/brf_read_port.sv
module brf_read_port
   import brf_pkg::*;
#(
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [IDX_W-1:0]  rd_idx,
   input  logic [DATA_W-1:0] gpr_q [NUM_REGS],
   input  logic [DATA_W-1:0] active_sp,
   input  logic [DATA_W-1:0] pc_rd,
   output logic [DATA_W-1:0] rd_data
);

   always_comb begin
      unique case (rd_idx)
         SP_IDX:  rd_data = active_sp;
         PC_IDX:  rd_data = pc_rd;
         default: rd_data = gpr_q[rd_idx];
      endcase
   end

   // R9: a program counter read never shows bit 0 set
   a_r9_pc_read_even : assert property (@(posedge clk) disable iff (!rst_n)
      (rd_idx == PC_IDX) |-> (rd_data[0] == 1'b0));

   // R2: index 13 shows the copy chosen by the select bit
   a_r2_index13_active : assert property (@(posedge clk) disable iff (!rst_n)
      (rd_idx == SP_IDX) |-> (rd_data == active_sp));

endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
   import brf_pkg::*;
#(
   parameter int unsigned       DATA_W     = 32,
   parameter int unsigned       ALIGN_BITS = 2,
   parameter logic [DATA_W-1:0] RESET_PC   = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctl_wr_en,
   input  logic              ctl_psp_sel,
   output logic              psp_active,
   input  logic [3:0]        rd_a_idx,
   output logic [DATA_W-1:0] rd_a_data,
   input  logic [3:0]        rd_b_idx,
   output logic [DATA_W-1:0] rd_b_data,
   input  logic              wr_en,
   input  logic [3:0]        wr_idx,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              spec_rd_sel,
   output logic [DATA_W-1:0] spec_rd_data,
   input  logic              spec_wr_en,
   input  logic              spec_wr_sel,
   input  logic [DATA_W-1:0] spec_wr_data,
   input  logic              stk_push,
   input  logic              stk_pop,
   output logic [DATA_W-1:0] stk_addr,
   input  logic              pc_adv,
   input  logic              pc_adv_wide,
   output logic [DATA_W-1:0] pc_addr,
   output logic              branch_fault
);

   if (DATA_W < 8) begin : g_bad_width
      $error("banked_regfile: DATA_W must be at least 8");
   end
   if (IDX_W != 4) begin : g_bad_idx
      $error("banked_regfile: port index width must be 4");
   end

   logic [DATA_W-1:0] gpr_q [NUM_REGS];
   logic [DATA_W-1:0] active_sp;
   logic [DATA_W-1:0] pc_rd;
   logic              gen_sp_wr;
   logic [IDX_W-1:0]  rd_idx  [NUM_RD];
   logic [DATA_W-1:0] rd_data [NUM_RD];

   assign gen_sp_wr = wr_en && (wr_idx == SP_IDX);

   brf_gpr_bank #(.DATA_W(DATA_W)) u_gpr (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_idx  (wr_idx),
      .wr_data (wr_data),
      .gpr_q   (gpr_q)
   );

   brf_sp_bank #(.DATA_W(DATA_W), .ALIGN_BITS(ALIGN_BITS)) u_sp (
      .clk          (clk),
      .rst_n        (rst_n),
      .ctl_wr_en    (ctl_wr_en),
      .ctl_psp_sel  (ctl_psp_sel),
      .gen_wr_en    (gen_sp_wr),
      .gen_wr_data  (wr_data),
      .spec_wr_en   (spec_wr_en),
      .spec_wr_sel  (spec_wr_sel),
      .spec_wr_data (spec_wr_data),
      .spec_rd_sel  (spec_rd_sel),
      .push         (stk_push),
      .pop          (stk_pop),
      .psp_active   (psp_active),
      .active_sp    (active_sp),
      .spec_rd_data (spec_rd_data),
      .stk_addr     (stk_addr)
   );

   brf_pc_unit #(.DATA_W(DATA_W), .RESET_PC(RESET_PC)) u_pc (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_idx   (wr_idx),
      .wr_data  (wr_data),
      .adv      (pc_adv),
      .adv_wide (pc_adv_wide),
      .pc_q     (pc_addr),
      .pc_rd    (pc_rd),
      .fault    (branch_fault)
   );

   assign rd_idx[0] = rd_a_idx;
   assign rd_idx[1] = rd_b_idx;

   for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
      brf_read_port #(.DATA_W(DATA_W)) u_port (
         .clk       (clk),
         .rst_n     (rst_n),
         .rd_idx    (rd_idx[p]),
         .gpr_q     (gpr_q),
         .active_sp (active_sp),
         .pc_rd     (pc_rd),
         .rd_data   (rd_data[p])
      );
   end

   assign rd_a_data = rd_data[0];
   assign rd_b_data = rd_data[1];

   // R12 / R1: a same-cycle write never shows through a read port
   a_r12_old_value_read : assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && rd_a_idx == wr_idx && wr_idx != PC_IDX && wr_idx != SP_IDX)
      |-> (rd_a_data == gpr_q[wr_idx]));

endmodule

// File: tb/banked_regfile_tb.sv
module banked_regfile_tb;

   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        ctl_wr_en, ctl_psp_sel, psp_active;
   logic [3:0]  rd_a_idx, rd_b_idx, wr_idx;
   logic [31:0] rd_a_data, rd_b_data, wr_data;
   logic        wr_en;
   logic        spec_rd_sel, spec_wr_en, spec_wr_sel;
   logic [31:0] spec_rd_data, spec_wr_data;
   logic        stk_push, stk_pop;
   logic [31:0] stk_addr;
   logic        pc_adv, pc_adv_wide;
   logic [31:0] pc_addr;
   logic        branch_fault;

   int  n_chk  = 0;
   int  n_fail = 0;
   bit  done   = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   banked_regfile u_dut (
      .clk(clk), .rst_n(rst_n),
      .ctl_wr_en(ctl_wr_en), .ctl_psp_sel(ctl_psp_sel), .psp_active(psp_active),
      .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
      .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
      .spec_rd_sel(spec_rd_sel), .spec_rd_data(spec_rd_data),
      .spec_wr_en(spec_wr_en), .spec_wr_sel(spec_wr_sel), .spec_wr_data(spec_wr_data),
      .stk_push(stk_push), .stk_pop(stk_pop), .stk_addr(stk_addr),
      .pc_adv(pc_adv), .pc_adv_wide(pc_adv_wide), .pc_addr(pc_addr),
      .branch_fault(branch_fault)
   );

   function automatic logic [31:0] pat(int i);
      return 32'h1357_9BDF ^ (32'(i) * 32'h0101_0101);
   endfunction

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic idle();
      ctl_wr_en = 0; ctl_psp_sel = 0; wr_en = 0; wr_idx = 0; wr_data = 0;
      spec_wr_en = 0; spec_wr_sel = 0; spec_wr_data = 0; spec_rd_sel = 0;
      stk_push = 0; stk_pop = 0; pc_adv = 0; pc_adv_wide = 0;
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog (all R) actual=timeout expected=completion");
         summary();
         $finish;
      end
   end

   initial begin
      rst_n = 0; idle(); rd_a_idx = 0; rd_b_idx = 0;
      step(); step();
      rst_n = 1;
      step();

      // R2 / R13: reset state
      check("R2 select after reset", 32'(psp_active), 32'd0);
      rd_a_idx = 4'd15; #1;
      check("R13 pc read after reset", rd_a_data, 32'd4);
      check("R13 pc address after reset", pc_addr, 32'd0);

      // R1: all plain registers read zero out of reset
      for (int i = 0; i < 15; i++) begin
         if (i == 13) continue;
         rd_a_idx = 4'(i); rd_b_idx = 4'(i); #1;
         check($sformatf("R1 reset zero port A idx %0d", i), rd_a_data, 32'd0);
         check($sformatf("R1 reset zero port B idx %0d", i), rd_b_data, 32'd0);
         step();
      end

      // R1 / R12: write sweep with same-cycle read of the same index
      for (int i = 0; i < 15; i++) begin
         if (i == 13) continue;
         wr_en = 1; wr_idx = 4'(i); wr_data = pat(i); rd_a_idx = 4'(i); #1;
         check($sformatf("R12 old value idx %0d", i), rd_a_data, 32'd0);
         step();
         wr_en = 0;
      end
      for (int i = 0; i < 15; i++) begin
         if (i == 13) continue;
         rd_a_idx = 4'(i); rd_b_idx = 4'(14 - i); #1;
         check($sformatf("R1 port A idx %0d", i), rd_a_data, pat(i));
         if (14 - i != 13)
            check($sformatf("R1 port B idx %0d", 14 - i), rd_b_data, pat(14 - i));
         step();
      end
      // R8: link register bit 0 kept
      rd_a_idx = 4'd14; #1;
      check("R8 link bit 0", 32'(rd_a_data[0]), 32'd1);

      // R3: alignment bits ignored on write via index 13
      wr_en = 1; wr_idx = 4'd13; wr_data = 32'hFFFF_FFFF;
      step(); wr_en = 0;
      rd_a_idx = 4'd13; spec_rd_sel = 0; #1;
      check("R3 main copy low bits", rd_a_data, 32'hFFFF_FFFC);
      check("R4 special read main", spec_rd_data, 32'hFFFF_FFFC);
      spec_rd_sel = 1; #1;
      check("R2 process copy untouched", spec_rd_data, 32'd0);

      // R4 / R3: special write to hidden copy
      spec_wr_en = 1; spec_wr_sel = 1; spec_wr_data = 32'h2000_0403;
      step(); spec_wr_en = 0;
      spec_rd_sel = 1; rd_a_idx = 4'd13; #1;
      check("R4 special write process", spec_rd_data, 32'h2000_0400);
      check("R2 index13 still main", rd_a_data, 32'hFFFF_FFFC);

      // R2: switch to process copy
      ctl_wr_en = 1; ctl_psp_sel = 1;
      step(); ctl_wr_en = 0;
      check("R2 select loaded", 32'(psp_active), 32'd1);
      rd_a_idx = 4'd13; #1;
      check("R2 index13 process", rd_a_data, 32'h2000_0400);

      // R5: push
      stk_push = 1; #1;
      check("R5 push address", stk_addr, 32'h2000_03FC);
      step(); stk_push = 0; #1;
      check("R5 push result", rd_a_data, 32'h2000_03FC);
      spec_rd_sel = 0; #1;
      check("R5 main copy untouched", spec_rd_data, 32'hFFFF_FFFC);

      // R6: pop
      stk_pop = 1; #1;
      check("R6 pop address", stk_addr, 32'h2000_03FC);
      step(); stk_pop = 0; #1;
      check("R6 pop result", rd_a_data, 32'h2000_0400);

      // R7: push and pop together act as push
      stk_push = 1; stk_pop = 1; #1;
      check("R7 both address", stk_addr, 32'h2000_03FC);
      step(); stk_push = 0; stk_pop = 0; #1;
      check("R7 both result", rd_a_data, 32'h2000_03FC);

      // R7: pop beats a write-port write to the active copy
      stk_pop = 1; wr_en = 1; wr_idx = 4'd13; wr_data = 32'h5555_5550;
      step(); stk_pop = 0; wr_en = 0; #1;
      check("R7 pop over write", rd_a_data, 32'h2000_0400);

      // R4: write port beats special port on the same copy
      wr_en = 1; wr_idx = 4'd13; wr_data = 32'h1111_1110;
      spec_wr_en = 1; spec_wr_sel = 1; spec_wr_data = 32'h2222_2220;
      step(); wr_en = 0; spec_wr_en = 0; #1;
      check("R4 write port priority", rd_a_data, 32'h1111_1110);

      // R2: back to main
      ctl_wr_en = 1; ctl_psp_sel = 0;
      step(); ctl_wr_en = 0; #1;
      check("R2 index13 main again", rd_a_data, 32'hFFFF_FFFC);

      // R9: program counter advance and read-ahead
      rd_a_idx = 4'd15; rd_b_idx = 4'd14;
      pc_adv = 1; pc_adv_wide = 1;
      step(); pc_adv = 0; #1;
      check("R9 wide advance", rd_a_data, 32'd8);
      pc_adv = 1; pc_adv_wide = 0;
      step(); pc_adv = 0; #1;
      check("R9 narrow advance", rd_a_data, 32'd10);
      check("R9 address after narrow", pc_addr, 32'd6);

      // R10: legal branch
      wr_en = 1; wr_idx = 4'd15; wr_data = 32'h0000_1235;
      step(); wr_en = 0; #1;
      check("R10 branch read", rd_a_data, 32'h0000_1238);
      check("R10 no fault", 32'(branch_fault), 32'd0);
      check("R10 link unchanged", rd_b_data, pat(14));

      // R11: illegal branch with an advance request
      wr_en = 1; wr_idx = 4'd15; wr_data = 32'h0000_2000; pc_adv = 1; pc_adv_wide = 1;
      step(); wr_en = 0; pc_adv = 0; #1;
      check("R11 fault raised", 32'(branch_fault), 32'd1);
      check("R11 pc held", rd_a_data, 32'h0000_1238);
      step();
      check("R11 fault cleared", 32'(branch_fault), 32'd0);

      done = 1'b1;
      summary();
      $finish;
   end

endmodule